// File: doc/BRIEF.md
# Ternary Rule Table with Hit Activity Tracking

This block is a small ternary content-addressable rule table. Every entry stores a key, a per-bit care mask, an action word, a valid flag and an activity flag. Lookup compares a search key against all valid entries in parallel. It returns whether any entry matched, the index of the winning entry and that entry's action word. Any entry that wins a lookup has its activity flag raised. Software can then tell which rules carried traffic.

A register-style access port reads or writes one entry at a time by index. The operation code selects the exact effect. Reads either leave the entry alone or return it and then drop its activity flag. Writes either install a whole entry, replace only the action word, or drop only the activity flag. The block accepts every request in the cycle it is presented and has no back-pressure. A read response appears exactly one cycle after the request, with `rsp_valid` high for one cycle. A lookup result appears one cycle after the search key, with `res_valid` high for one cycle. The requester must accept both responses when they appear, because neither can be held off.

Top module: `tcam_rule_table`

## Requirements
- R1: After reset every entry is invalid and inactive, `rsp_valid` and `res_valid` are low, and any lookup misses.
- R2: A read (`acc_wr`=0) with any opcode other than 1 returns valid, activity, key, mask and action of the addressed entry on the response outputs one cycle later, with `rsp_valid` high, and changes nothing.
- R3: A read with opcode 1 returns the entry as in R2, showing the activity flag as it was before the read, and then clears that entry's activity flag.
- R4: A write (`acc_wr`=1) with opcode 0 stores valid, key, mask and action and sets the entry's activity flag. With `acc_valid_in`=0 the entry is deleted and no longer matches any lookup.
- R5: A write with opcode 1 replaces only the action word. Valid, key, mask and activity stay unchanged.
- R6: A write with opcode 2 clears only the addressed entry's activity flag.
- R7: Writes with opcodes 3 to 7 change no entry.
- R8: An entry matches when it is valid and, for every bit where its mask is 1, the search key bit equals the stored key bit. Bits where the mask is 0 are ignored.
- R9: When several valid entries match, the one with the lowest index wins.
- R10: The lookup result is registered. `res_valid`, `res_hit`, `res_index` and `res_action` show the result one cycle after `lkp_req`. A hit sets the winner's activity flag. A miss reports index 0 and action 0.
- R11: If a lookup hit and an activity clear (read opcode 1 or write opcode 2) hit the same entry in one cycle, the entry stays active.
- R12: Only the low log2(DEPTH) bits of the 16-bit `acc_index` select the entry, so with 16 entries index 21 addresses entry 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access request strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_op | input | 3 | Operation code |
| acc_index | input | 16 | Entry index (low bits used) |
| acc_valid_in | input | 1 | Valid flag for a full write |
| acc_key_in | input | KEY_W | Key for a full write |
| acc_mask_in | input | KEY_W | Care mask for a full write |
| acc_action_in | input | ACT_W | Action word for full or action-only write |
| rsp_valid | output | 1 | Read response valid |
| rsp_entry_valid | output | 1 | Valid flag of the read entry |
| rsp_active | output | 1 | Activity flag of the read entry |
| rsp_key | output | KEY_W | Key of the read entry |
| rsp_mask | output | KEY_W | Mask of the read entry |
| rsp_action | output | ACT_W | Action word of the read entry |
| lkp_req | input | 1 | Lookup request strobe |
| lkp_key | input | KEY_W | Search key |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup matched an entry |
| res_index | output | IDX_W | Index of the winning entry |
| res_action | output | ACT_W | Action word of the winning entry |

## Verification
Lookups are tried against a mix of three rule kinds: an exact-match rule, a rule that ignores the low key byte, and a rule that compares only the top 16 bits. The mix includes keys that differ from a stored key in a masked bit and keys that differ in a cared bit. This separates the mask semantics from plain equality. Keys that match two rules at once show whether the lowest index wins. Deleting the lower rule shows whether the next one takes over. Adding a catch-all rule at a high index confirms that it only wins when nothing lower matches. The activity flag is probed through reads after installs, lookups, clear-on-read, the explicit clear and a same-cycle lookup and clear. Each probe separates set, clear and their priority.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  localparam int unsigned OP_W  = 3;
  localparam int unsigned IDX_IN_W = 16;

  // Read-side operation codes
  typedef enum logic [OP_W-1:0] {
    RD_PEEK = 3'd0,
    RD_TAKE = 3'd1
  } rd_op_e;

  // Write-side operation codes
  typedef enum logic [OP_W-1:0] {
    WR_INSTALL  = 3'd0,
    WR_RETARGET = 3'd1,
    WR_QUIET    = 3'd2
  } wr_op_e;

endpackage

// File: rtl/tcam_op_decode.sv
module tcam_op_decode
  import tcam_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                acc_req,
  input  logic                acc_wr,
  input  logic [OP_W-1:0]     acc_op,
  input  logic [IDX_IN_W-1:0] acc_index,
  output logic [IW-1:0]       sel_idx,
  output logic                rd_fire,
  output logic [DEPTH-1:0]    install_vec,
  output logic [DEPTH-1:0]    retarget_vec,
  output logic [DEPTH-1:0]    clear_vec
);

  logic [DEPTH-1:0] sel_oh;
  logic             is_install;
  logic             is_retarget;
  logic             is_quiet;
  logic             is_take;

  assign sel_idx = acc_index[IW-1:0];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
      assign sel_oh[g] = (sel_idx == IW'(g));
    end
  endgenerate

  always_comb begin
    is_install  = 1'b0;
    is_retarget = 1'b0;
    is_quiet    = 1'b0;
    is_take     = 1'b0;
    rd_fire     = 1'b0;
    if (acc_req) begin
      if (acc_wr) begin
        unique case (acc_op)
          WR_INSTALL:  is_install  = 1'b1;
          WR_RETARGET: is_retarget = 1'b1;
          WR_QUIET:    is_quiet    = 1'b1;
          default:     ;
        endcase
      end else begin
        rd_fire = 1'b1;
        is_take = (acc_op == RD_TAKE);
      end
    end
  end

  assign install_vec  = is_install  ? sel_oh : '0;
  assign retarget_vec = is_retarget ? sel_oh : '0;
  assign clear_vec    = (is_quiet || is_take) ? sel_oh : '0;

endmodule

// File: rtl/tcam_entry_store.sv
module tcam_entry_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned KW    = 64,
  parameter int unsigned AW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0]          install_vec,
  input  logic [DEPTH-1:0]          retarget_vec,
  input  logic [DEPTH-1:0]          clear_vec,
  input  logic [DEPTH-1:0]          set_vec,
  input  logic                      wr_valid,
  input  logic [KW-1:0]             wr_key,
  input  logic [KW-1:0]             wr_mask,
  input  logic [AW-1:0]             wr_action,
  output logic [DEPTH-1:0]          ent_valid,
  output logic [DEPTH-1:0]          ent_act,
  output logic [DEPTH-1:0][KW-1:0]  ent_key,
  output logic [DEPTH-1:0][KW-1:0]  ent_mask,
  output logic [DEPTH-1:0][AW-1:0]  ent_action
);

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic act_next;

      // set (lookup or install) dominates clear
      always_comb begin
        if (install_vec[e] || set_vec[e]) act_next = 1'b1;
        else if (clear_vec[e])            act_next = 1'b0;
        else                              act_next = ent_act[e];
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ent_valid[e]  <= 1'b0;
          ent_act[e]    <= 1'b0;
          ent_key[e]    <= '0;
          ent_mask[e]   <= '0;
          ent_action[e] <= '0;
        end else begin
          ent_act[e] <= act_next;
          if (install_vec[e]) begin
            ent_valid[e] <= wr_valid;
            ent_key[e]   <= wr_key;
            ent_mask[e]  <= wr_mask;
          end
          if (install_vec[e] || retarget_vec[e]) begin
            ent_action[e] <= wr_action;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/tcam_match_array.sv
module tcam_match_array #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned KW    = 64,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [KW-1:0]             srch_key,
  input  logic [DEPTH-1:0]          ent_valid,
  input  logic [DEPTH-1:0][KW-1:0]  ent_key,
  input  logic [DEPTH-1:0][KW-1:0]  ent_mask,
  output logic                      any_hit,
  output logic [IW-1:0]             win_idx,
  output logic [DEPTH-1:0]          win_vec
);

  logic [DEPTH-1:0] match_vec;

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
      assign match_vec[e] = ent_valid[e] &&
                            (((srch_key ^ ent_key[e]) & ent_mask[e]) == '0);
    end
  endgenerate

  // lowest index takes priority
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    win_vec = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IW'(i);
        win_vec = '0;
        win_vec[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tcam_rule_table.sv
module tcam_rule_table
  import tcam_pkg::*;
#(
  parameter int unsigned KEY_W = 64,
  parameter int unsigned ACT_W = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_req,
  input  logic                acc_wr,
  input  logic [OP_W-1:0]     acc_op,
  input  logic [IDX_IN_W-1:0] acc_index,
  input  logic                acc_valid_in,
  input  logic [KEY_W-1:0]    acc_key_in,
  input  logic [KEY_W-1:0]    acc_mask_in,
  input  logic [ACT_W-1:0]    acc_action_in,
  output logic                rsp_valid,
  output logic                rsp_entry_valid,
  output logic                rsp_active,
  output logic [KEY_W-1:0]    rsp_key,
  output logic [KEY_W-1:0]    rsp_mask,
  output logic [ACT_W-1:0]    rsp_action,
  input  logic                lkp_req,
  input  logic [KEY_W-1:0]    lkp_key,
  output logic                res_valid,
  output logic                res_hit,
  output logic [IDX_W-1:0]    res_index,
  output logic [ACT_W-1:0]    res_action
);

  logic [IDX_W-1:0]               sel_idx;
  logic                           rd_fire;
  logic [DEPTH-1:0]               install_vec;
  logic [DEPTH-1:0]               retarget_vec;
  logic [DEPTH-1:0]               clear_vec;
  logic [DEPTH-1:0]               set_vec;
  logic [DEPTH-1:0]               ent_valid;
  logic [DEPTH-1:0]               ent_act;
  logic [DEPTH-1:0][KEY_W-1:0]    ent_key;
  logic [DEPTH-1:0][KEY_W-1:0]    ent_mask;
  logic [DEPTH-1:0][ACT_W-1:0]    ent_action;
  logic                           any_hit;
  logic [IDX_W-1:0]               win_idx;
  logic [DEPTH-1:0]               win_vec;

  tcam_op_decode #(.DEPTH(DEPTH)) dec_i (
    .acc_req      (acc_req),
    .acc_wr       (acc_wr),
    .acc_op       (acc_op),
    .acc_index    (acc_index),
    .sel_idx      (sel_idx),
    .rd_fire      (rd_fire),
    .install_vec  (install_vec),
    .retarget_vec (retarget_vec),
    .clear_vec    (clear_vec)
  );

  tcam_match_array #(.DEPTH(DEPTH), .KW(KEY_W)) mat_i (
    .srch_key  (lkp_key),
    .ent_valid (ent_valid),
    .ent_key   (ent_key),
    .ent_mask  (ent_mask),
    .any_hit   (any_hit),
    .win_idx   (win_idx),
    .win_vec   (win_vec)
  );

  assign set_vec = lkp_req ? win_vec : '0;

  tcam_entry_store #(.DEPTH(DEPTH), .KW(KEY_W), .AW(ACT_W)) st_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .install_vec  (install_vec),
    .retarget_vec (retarget_vec),
    .clear_vec    (clear_vec),
    .set_vec      (set_vec),
    .wr_valid     (acc_valid_in),
    .wr_key       (acc_key_in),
    .wr_mask      (acc_mask_in),
    .wr_action    (acc_action_in),
    .ent_valid    (ent_valid),
    .ent_act      (ent_act),
    .ent_key      (ent_key),
    .ent_mask     (ent_mask),
    .ent_action   (ent_action)
  );

  // read response: captures entry state before this edge's update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_entry_valid <= 1'b0;
      rsp_active      <= 1'b0;
      rsp_key         <= '0;
      rsp_mask        <= '0;
      rsp_action      <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        rsp_entry_valid <= ent_valid[sel_idx];
        rsp_active      <= ent_act[sel_idx];
        rsp_key         <= ent_key[sel_idx];
        rsp_mask        <= ent_mask[sel_idx];
        rsp_action      <= ent_action[sel_idx];
      end
    end
  end

  // lookup result register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_index  <= '0;
      res_action <= '0;
    end else begin
      res_valid <= lkp_req;
      if (lkp_req) begin
        res_hit    <= any_hit;
        res_index  <= any_hit ? win_idx : '0;
        res_action <= any_hit ? ent_action[win_idx] : '0;
      end
    end
  end

endmodule

// File: rtl/tcam_rule_table_chk.sv
module tcam_rule_table_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned KW    = 64,
  parameter int unsigned IW    = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_req,
  input logic                      acc_wr,
  input logic [2:0]                acc_op,
  input logic [15:0]               acc_index,
  input logic                      acc_valid_in,
  input logic                      lkp_req,
  input logic                      rsp_valid,
  input logic                      res_valid,
  input logic                      res_hit,
  input logic [IW-1:0]             res_index,
  input logic [DEPTH-1:0]          ent_valid,
  input logic [DEPTH-1:0]          ent_act,
  input logic [DEPTH-1:0][KW-1:0]  ent_key,
  input logic [DEPTH-1:0][KW-1:0]  ent_mask
);

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_wr) |=> rsp_valid); // R2

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_req && !acc_wr) |=> !rsp_valid); // R2

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |=> res_valid); // R10

  AST_HIT_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> ent_act[res_index]); // R10

  AST_DELETE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_wr && acc_op == 3'd0 && !acc_valid_in)
      |=> !ent_valid[$past(acc_index[IW-1:0])]); // R4

  AST_RETARGET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_wr && acc_op == 3'd1)
      |=> ($stable(ent_valid) && $stable(ent_key) && $stable(ent_mask))); // R5

  AST_QUIET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_wr && acc_op == 3'd2 && !lkp_req)
      |=> !ent_act[$past(acc_index[IW-1:0])]); // R6

  AST_IGNORED_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_wr && acc_op > 3'd2)
      |=> ($stable(ent_valid) && $stable(ent_key) && $stable(ent_mask))); // R7

endmodule

bind tcam_rule_table tcam_rule_table_chk #(
  .DEPTH(DEPTH), .KW(KEY_W), .IW(IDX_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_req      (acc_req),
  .acc_wr       (acc_wr),
  .acc_op       (acc_op),
  .acc_index    (acc_index),
  .acc_valid_in (acc_valid_in),
  .lkp_req      (lkp_req),
  .rsp_valid    (rsp_valid),
  .res_valid    (res_valid),
  .res_hit      (res_hit),
  .res_index    (res_index),
  .ent_valid    (ent_valid),
  .ent_act      (ent_act),
  .ent_key      (ent_key),
  .ent_mask     (ent_mask)
);

// File: tb/tcam_rule_table_tb.sv
module tcam_rule_table_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int KW = 64;
  localparam int AW = 32;
  localparam int DEPTH = 16;
  localparam int IW = 4;
  localparam logic [31:0] ACT_BASE = 32'hA5A5_0000;
  localparam logic [63:0] ALL1 = '1;

  // lookup vectors: key, expected hit, expected index
  localparam int NV = 8;
  localparam logic [63:0] V_KEY [NV] = '{
    64'h0000_0000_0000_1234, 64'h0000_0000_0000_12AB,
    64'h0000_0000_0000_1334, 64'hDEAD_1111_2222_3333,
    64'hDEAE_0000_0000_0000, 64'h0000_0000_0000_1200,
    64'hDEAD_0000_0000_1234, 64'h0000_0000_0000_0000};
  localparam logic V_HIT [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [3:0] V_IDX [NV] = '{4'd2, 4'd3, 4'd0, 4'd5, 4'd0, 4'd3, 4'd5, 4'd0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_req = 1'b0, acc_wr = 1'b0, acc_valid_in = 1'b0;
  logic [2:0] acc_op = '0;
  logic [15:0] acc_index = '0;
  logic [KW-1:0] acc_key_in = '0, acc_mask_in = '0;
  logic [AW-1:0] acc_action_in = '0;
  logic rsp_valid, rsp_entry_valid, rsp_active;
  logic [KW-1:0] rsp_key, rsp_mask;
  logic [AW-1:0] rsp_action;
  logic lkp_req = 1'b0;
  logic [KW-1:0] lkp_key = '0;
  logic res_valid, res_hit;
  logic [IW-1:0] res_index;
  logic [AW-1:0] res_action;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcam_rule_table #(.KEY_W(KW), .ACT_W(AW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_op(acc_op), .acc_index(acc_index),
    .acc_valid_in(acc_valid_in), .acc_key_in(acc_key_in), .acc_mask_in(acc_mask_in),
    .acc_action_in(acc_action_in),
    .rsp_valid(rsp_valid), .rsp_entry_valid(rsp_entry_valid), .rsp_active(rsp_active),
    .rsp_key(rsp_key), .rsp_mask(rsp_mask), .rsp_action(rsp_action),
    .lkp_req(lkp_req), .lkp_key(lkp_key),
    .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index), .res_action(res_action)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] op, input int idx, input logic v,
                    input logic [63:0] k, input logic [63:0] m, input logic [31:0] a);
    @(negedge clk);
    acc_req = 1'b1; acc_wr = 1'b1; acc_op = op; acc_index = 16'(idx);
    acc_valid_in = v; acc_key_in = k; acc_mask_in = m; acc_action_in = a;
    @(negedge clk);
    acc_req = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] op, input int idx);
    @(negedge clk);
    acc_req = 1'b1; acc_wr = 1'b0; acc_op = op; acc_index = 16'(idx);
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  task automatic look(input logic [63:0] k);
    @(negedge clk);
    lkp_req = 1'b1; lkp_key = k;
    @(negedge clk);
    lkp_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 0);
    check(res_valid == 1'b0, "R1", "res_valid after reset", 64'(res_valid), 0);
    look(64'h0);
    check(res_valid && !res_hit, "R1", "lookup after reset misses", 64'(res_hit), 0);
    rd(3'd0, 7);
    check(!rsp_entry_valid && !rsp_active, "R1", "entry 7 cleared by reset",
          64'({rsp_entry_valid, rsp_active}), 0);

    // program rules
    wr(3'd0, 2, 1'b1, 64'h0000_0000_0000_1234, ALL1, ACT_BASE + 2);
    wr(3'd0, 3, 1'b1, 64'h0000_0000_0000_1200, 64'hFFFF_FFFF_FFFF_FF00, ACT_BASE + 3);
    wr(3'd0, 5, 1'b1, 64'hDEAD_0000_0000_0000, 64'hFFFF_0000_0000_0000, ACT_BASE + 5);

    // R4 install readback via R2 peek
    rd(3'd0, 2);
    check(rsp_valid, "R2", "rsp_valid on read", 64'(rsp_valid), 1);
    check(rsp_entry_valid && rsp_active, "R4", "install sets valid and active",
          64'({rsp_entry_valid, rsp_active}), 64'b11);
    check(rsp_key == 64'h1234 && rsp_mask == ALL1, "R4", "installed key/mask", rsp_key, 64'h1234);
    check(rsp_action == ACT_BASE + 2, "R4", "installed action", 64'(rsp_action), 64'(ACT_BASE + 2));
    @(negedge clk);
    check(!rsp_valid, "R2", "rsp_valid single cycle", 64'(rsp_valid), 0);

    // table-driven lookups: R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      look(V_KEY[i]);
      check(res_valid, "R10", "res_valid one cycle later", 64'(res_valid), 1);
      check(res_hit == V_HIT[i], "R8", $sformatf("hit for vector %0d", i), 64'(res_hit), 64'(V_HIT[i]));
      check(res_index == V_IDX[i], "R9", $sformatf("index for vector %0d", i), 64'(res_index), 64'(V_IDX[i]));
      check(res_action == (V_HIT[i] ? ACT_BASE + 32'(V_IDX[i]) : 32'h0), "R10",
            $sformatf("action for vector %0d", i), 64'(res_action),
            64'(V_HIT[i] ? ACT_BASE + 32'(V_IDX[i]) : 32'h0));
    end

    // R6 clear activity op only
    wr(3'd2, 2, 1'b0, 64'h0, 64'h0, 32'h0);
    rd(3'd0, 2);
    check(!rsp_active, "R6", "activity cleared", 64'(rsp_active), 0);
    check(rsp_entry_valid && rsp_key == 64'h1234 && rsp_action == ACT_BASE + 2, "R6",
          "rest unchanged", rsp_key, 64'h1234);

    // R10 lookup hit sets activity
    look(64'h1234);
    rd(3'd0, 2);
    check(rsp_active, "R10", "hit sets activity", 64'(rsp_active), 1);

    // R3 clear on read
    rd(3'd1, 2);
    check(rsp_active, "R3", "take returns prior activity", 64'(rsp_active), 1);
    rd(3'd0, 2);
    check(!rsp_active, "R3", "take clears activity", 64'(rsp_active), 0);

    // R5 action-only update
    wr(3'd1, 3, 1'b0, 64'hFFFF, 64'h0, 32'h1357_9BDF);
    rd(3'd4, 3);
    check(rsp_action == 32'h1357_9BDF, "R5", "action replaced", 64'(rsp_action), 64'h1357_9BDF);
    check(rsp_entry_valid && rsp_active && rsp_key == 64'h1200 &&
          rsp_mask == 64'hFFFF_FFFF_FFFF_FF00, "R5", "key/mask/valid/activity kept", rsp_key, 64'h1200);

    // R7 ignored write opcode
    wr(3'd5, 3, 1'b0, 64'h0, 64'h0, 32'h0);
    rd(3'd0, 3);
    check(rsp_entry_valid && rsp_key == 64'h1200 && rsp_action == 32'h1357_9BDF, "R7",
          "opcode 5 changes nothing", 64'(rsp_action), 64'h1357_9BDF);

    // R12 index aliasing
    rd(3'd0, 21);
    check(rsp_key == 64'hDEAD_0000_0000_0000, "R12", "index 21 reaches entry 5",
          rsp_key, 64'hDEAD_0000_0000_0000);

    // R11 same-cycle lookup set and activity clear on entry 5
    @(negedge clk);
    lkp_req = 1'b1; lkp_key = 64'hDEAD_0000_0000_0001;
    acc_req = 1'b1; acc_wr = 1'b1; acc_op = 3'd2; acc_index = 16'd5;
    @(negedge clk);
    lkp_req = 1'b0; acc_req = 1'b0; acc_wr = 1'b0;
    check(res_hit && res_index == 4'd5, "R11", "lookup hit entry 5", 64'(res_index), 5);
    rd(3'd0, 5);
    check(rsp_active, "R11", "set wins over clear", 64'(rsp_active), 1);

    // R4 delete, R9 next entry takes over
    wr(3'd0, 2, 1'b0, 64'h1234, ALL1, 32'h0);
    look(64'h1234);
    check(res_hit && res_index == 4'd3, "R4", "deleted rule no longer matches",
          64'(res_index), 3);

    // R9 catch-all at high index wins only when nothing lower matches
    wr(3'd0, 9, 1'b1, 64'h0, 64'h0, ACT_BASE + 9);
    look(64'h0000_0000_0000_1334);
    check(res_hit && res_index == 4'd9, "R8", "mask zero matches any key", 64'(res_index), 9);
    look(64'h0000_0000_0000_12AB);
    check(res_hit && res_index == 4'd3, "R9", "lower index beats catch-all", 64'(res_index), 3);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule